// File: doc/BRIEF.md
# Priority interrupt level selector

This block collects interrupt requests and chooses the one a processor core should take next. It keeps a latched vector of sixteen request lines. Each line changes through single raise or lower events. This vector is merged with a software-interrupt register. In that register, the timer soft bit (bit 0) is moved up to level 14 and all other bits count at their own positions. The highest pending level from 15 down to 1 becomes a trap code in the external-interrupt class.

The core supplies the trap code it currently has pending. A new selection may replace that code only when nothing is pending or when the pending code already belongs to the external-interrupt class. When the block changes the code, it raises a one-cycle hard-interrupt set strobe. When every request has gone away while an external-class code is pending, it returns the code to zero and raises a one-cycle clear strobe. Any raise event also pulses a wake output, which takes the core out of its halted state.

Top module: `irq_level_sel`

## Requirements
- R1: After synchronous reset, `trap_code` is 0, `hard_set`, `hard_clr` and `wake` are 0, and all latched request lines are clear.
- R2: An event with `evt_raise`=1 sets latched line `evt_line`, and an event with `evt_raise`=0 clears it. Other lines are unchanged. The updated vector is used in the same cycle's evaluation.
- R3: `wake` is 1 in the cycle after a raise event and 0 otherwise. Lower events do not produce a wake pulse.
- R4: The pending vector is the latched lines ORed with `soft_in` with bit 0 removed, ORed with `soft_in[0]` placed at level 14.
- R5: The selected level is the highest set pending bit in 15..1. The new trap code is `EXT_CLASS` (default 0x040, low 4 bits zero) ORed with that level in bits 3:0.
- R6: A selection is applied only if `cur_trap` is 0 or `cur_trap[8:4]` equals `EXT_CLASS[8:4]`. In every other case, `trap_code` repeats `cur_trap` and no strobe occurs.
- R7: `hard_set` pulses when an applied selection gives a code different from `cur_trap`. When the code is the same, no strobe occurs.
- R8: If the pending vector is entirely zero and `cur_trap` is external-class, `trap_code` becomes 0 and `hard_clr` pulses.
- R9: If only pending bit 0 is set, nothing is selected and nothing is cleared. `trap_code` repeats `cur_trap`.
- R10: All outputs are registered, one clock edge after the inputs they depend on. When no action applies, `trap_code` repeats `cur_trap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_valid | input | 1 | A line event is present this cycle |
| evt_raise | input | 1 | 1 raises the line, 0 lowers it |
| evt_line | input | 4 | Index of the line the event applies to |
| soft_in | input | 16 | Software-interrupt register value; bit 0 is the timer soft bit |
| cur_trap | input | 9 | Trap code currently pending in the core |
| trap_code | output | 9 | Updated trap code for the core |
| hard_set | output | 1 | One-cycle strobe: assert the hard-interrupt request |
| hard_clr | output | 1 | One-cycle strobe: withdraw the hard-interrupt request |
| wake | output | 1 | One-cycle strobe: leave the halted state |

## Verification
Random line events run together with sparse random software words. This shows that the highest level wins and that the timer bit lands on level 14 rather than level 0. The pending code is drawn from zero, from external-class codes and from codes of other classes, so the override rule is tested on both sides of the class comparison. Feeding the block's own output back as the pending code makes repeated selections of the same level, which checks that no strobe is produced when nothing changes. Directed cases cover a pending vector that holds only bit 0, the return to zero after the last line is lowered, and a lower event that must not produce a wake pulse.

// File: rtl/irq_level_sel.sv
module irq_level_sel #(
  parameter int NLVL = 16,
  parameter int TW = 9,
  parameter logic [TW-1:0] EXT_CLASS = 9'h040,
  parameter int TMR_LVL = 14,
  localparam int LW = $clog2(NLVL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_valid,
  input  logic          evt_raise,
  input  logic [LW-1:0] evt_line,
  input  logic [NLVL-1:0] soft_in,
  input  logic [TW-1:0] cur_trap,
  output logic [TW-1:0] trap_code,
  output logic          hard_set,
  output logic          hard_clr,
  output logic          wake
);

  logic [NLVL-1:0] req_q, req_d, pend;
  logic [LW-1:0]   lvl;
  logic            hit, ext, open_slot;
  logic [TW-1:0]   cand;

  always_comb begin
    req_d = req_q;
    if (evt_valid) req_d[evt_line] = evt_raise;
  end

  assign pend = req_d | {soft_in[NLVL-1:1], 1'b0} | (NLVL'(soft_in[0]) << TMR_LVL);

  always_comb begin
    lvl = '0;
    for (int i = 1; i < NLVL; i++)
      if (pend[i]) lvl = LW'(i);
  end

  assign hit       = |pend[NLVL-1:1];
  assign ext       = cur_trap[TW-1:LW] == EXT_CLASS[TW-1:LW];
  assign open_slot = (cur_trap == '0) || ext;
  assign cand      = EXT_CLASS | TW'(lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= '0;
      trap_code <= '0;
      hard_set  <= 1'b0;
      hard_clr  <= 1'b0;
      wake      <= 1'b0;
    end else begin
      req_q     <= req_d;
      wake      <= evt_valid && evt_raise;
      hard_set  <= 1'b0;
      hard_clr  <= 1'b0;
      trap_code <= cur_trap;
      if (hit && open_slot) begin
        trap_code <= cand;
        hard_set  <= cand != cur_trap;
      end else if (pend == '0 && ext) begin
        trap_code <= '0;
        hard_clr  <= 1'b1;
      end
    end
  end

  assert_line_update_R2: assert property (@(posedge clk) disable iff (rst)
    evt_valid |=> req_q[$past(evt_line)] == $past(evt_raise));

  assert_wake_on_raise_R3: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_raise) |=> wake);

  assert_set_code_class_R5: assert property (@(posedge clk) disable iff (rst)
    hard_set |-> (trap_code[TW-1:LW] == EXT_CLASS[TW-1:LW] && trap_code[LW-1:0] != '0));

  assert_foreign_trap_kept_R6: assert property (@(posedge clk) disable iff (rst)
    !open_slot |=> (!hard_set && !hard_clr && trap_code == $past(cur_trap)));

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
    hard_clr |-> trap_code == '0);

  assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hard_set, hard_clr}));

endmodule

// File: tb/irq_level_sel_tb.sv
`timescale 1ns/1ps
module irq_level_sel_tb_top;
  logic clk = 0, rst = 1;
  logic evt_valid = 0, evt_raise = 0;
  logic [3:0] evt_line = 0;
  logic [15:0] soft_in = 0;
  logic [8:0] cur_trap = 0;
  logic [8:0] trap_code;
  logic hard_set, hard_clr, wake;

  int checks = 0, errors = 0;
  logic [15:0] mreq = 0;
  logic [8:0] e_code;
  logic e_set, e_clr, e_wake;
  string tag;

  always #2.5 clk = ~clk;

  irq_level_sel dut_i (.clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_raise(evt_raise),
    .evt_line(evt_line), .soft_in(soft_in), .cur_trap(cur_trap), .trap_code(trap_code),
    .hard_set(hard_set), .hard_clr(hard_clr), .wake(wake));

  function automatic logic [15:0] merged(input logic [15:0] r, input logic [15:0] s);
    return r | {s[15:1], 1'b0} | (s[0] ? 16'h4000 : 16'h0);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic r, input logic [3:0] ln,
                      input logic [15:0] s, input logic [8:0] ct);
    logic [15:0] p;
    int top;
    logic ext;
    @(negedge clk);
    evt_valid = v; evt_raise = r; evt_line = ln; soft_in = s; cur_trap = ct;
    if (v) mreq[ln] = r;
    p = merged(mreq, s);
    top = 0;
    for (int i = 1; i < 16; i++) if (p[i]) top = i;
    ext = ct[8:4] == 5'h04;
    e_code = ct; e_set = 0; e_clr = 0; e_wake = v && r;
    if (top != 0 && (ct == 0 || ext)) begin
      e_code = 9'h040 | 9'(top); e_set = e_code != ct;
      tag = e_set ? "R5/R7" : "R7";
    end else if (p == 0 && ext) begin
      e_code = 0; e_clr = 1; tag = "R8";
    end else if (top != 0) tag = "R6";
    else if (p[0]) tag = "R9";
    else tag = "R10";
    @(posedge clk); #1;
    check({tag, " code"}, 32'(trap_code), 32'(e_code));
    check({tag, " set"}, 32'(hard_set), 32'(e_set));
    check({tag, " clr"}, 32'(hard_clr), 32'(e_clr));
    check("R3 wake", 32'(wake), 32'(e_wake));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 code", 32'(trap_code), 0);
    check("R1 set", 32'(hard_set), 0);
    check("R1 clr", 32'(hard_clr), 0);
    check("R1 wake", 32'(wake), 0);
    @(negedge clk); rst = 0;
    step(0, 0, 0, 16'h0000, 9'h000);
    step(1, 1, 4'd3, 16'h0000, 9'h000);
    check("R2 raise line3", 32'(trap_code), 32'h043);
    step(0, 0, 0, 16'h0001, 9'h043);
    check("R4 timer at 14", 32'(trap_code), 32'h04e);
    step(0, 0, 0, 16'h8000, 9'h04e);
    check("R5 level15 wins", 32'(trap_code), 32'h04f);
    step(0, 0, 0, 16'h8000, 9'h04f);
    check("R7 no repeat set", 32'(hard_set), 0);
    step(1, 0, 4'd3, 16'h0000, 9'h04f);
    check("R2 lower clears", 32'(trap_code), 32'h000);
    check("R8 clear strobe", 32'(hard_clr), 1);
    check("R3 no wake on lower", 32'(wake), 0);
    step(1, 1, 4'd0, 16'h0000, 9'h045);
    check("R9 level0 only", 32'(trap_code), 32'h045);
    step(1, 1, 4'd9, 16'h0000, 9'h061);
    check("R6 foreign kept", 32'(trap_code), 32'h061);
    step(1, 0, 4'd9, 16'h0000, 9'h000);
    step(1, 0, 4'd0, 16'h0000, 9'h000);
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] s;
      logic [8:0] ct;
      logic [31:0] k;
      s = 16'($urandom) & 16'($urandom) & 16'($urandom);
      k = $urandom % 8;
      case (k)
        0, 1: ct = 9'h000;
        2, 3: ct = 9'h040 | 9'($urandom % 16);
        4:    ct = 9'($urandom);
        default: ct = trap_code;
      endcase
      if (($urandom % 4) == 0) s = 16'h0;
      step(($urandom % 3) != 0, ($urandom % 2) == 0, 4'($urandom), s, ct);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule